// File: doc/BRIEF.md
# Two-Bit Serial Write Slave

This block terminates a narrow serial write channel. A master raises a request line and, for as long as it stays high, puts two bits per clock on a two-bit data bus. The slave counts the cycles of the request, rebuilds a 17-bit address and a data word from the bit pairs, and on the falling edge of the request decides whether the frame is a well-formed write. Accepted frames appear on a parallel local write port (address, data, byte enable, enable). They are stored in a small internal register bank, and the master receives a one-cycle acknowledge.

A static input selects the payload width: a 32-bit word or a single byte. A frame begins with a header cycle. Bus bit 0 of that cycle is the write flag and bus bit 1 carries address bit 0. Eight cycles of address pairs follow, then the data pairs, lowest pair first. The frame length is 25 cycles for words and 13 cycles for bytes. Frames of the wrong length, frames without the write flag and frames whose address lies outside the bank's window are dropped without an acknowledge. The bank has a combinational inspection port so that local logic can read what was stored.

Top module: `pairbus_wr_slave`

## Requirements
- R1: With `wide_mode` = 1, a frame that holds `req` high for exactly 25 consecutive cycles, with the write flag set, produces one local write of the full 32-bit word.
- R2: With `wide_mode` = 0, a frame that holds `req` high for exactly 13 consecutive cycles, with the write flag set, produces one local write.
- R3: If `din[0]` is 0 in the first cycle of `req`, the frame is not a write. It causes no local write, no acknowledge and no change in the bank.
- R4: Address assembly: address bit 0 is `din[1]` of the first cycle. In request cycle k (k = 1..8, counting the first cycle as 0), `din[1]` is address bit 2k and `din[0]` is address bit 2k-1.
- R5: Data assembly: in request cycle 9+j, `din[1]` is data bit 2j+1 and `din[0]` is data bit 2j, so the lowest pair arrives first.
- R6: If the last high cycle of a valid frame is sampled at edge E-1 and `req` is sampled low at edge E, then `lw_en` is high for exactly one cycle, from edge E+1 to edge E+2.
- R7: `ack` is a one-cycle pulse that rises in the cycle directly after every `lw_en` cycle. It never appears otherwise.
- R8: A frame whose high time differs from the count for the current mode (shorter or longer) is discarded. It causes no local write and no acknowledge.
- R9: In byte mode, `lw_be` = 4'b0001 and `lw_data[31:8]` = 0. Only bits [7:0] of the addressed bank location change.
- R10: In word mode, `lw_be` = 4'b1111 and all 32 bits of the addressed location are replaced.
- R11: Only addresses from `BASE_ADDR` to `BASE_ADDR + BANK_DEPTH - 1` are accepted. Location index = address - `BASE_ADDR`. Any other address causes no write and no acknowledge.
- R12: While `rst` is high and after it falls, `lw_en` and `ack` are 0 and every bank location reads 0.
- R13: `peek_data` shows, in the same cycle, the bank location selected by `peek_idx`. A write becomes visible after the edge that ends its `lw_en` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | Payload width select: 1 = 32-bit word, 0 = byte |
| req | input | 1 | Frame request, held high for the whole frame |
| din | input | 2 | Serial bit pair |
| lw_en | output | 1 | Local write enable, one cycle per accepted frame |
| lw_addr | output | 17 | Local write address |
| lw_data | output | 32 | Local write data |
| lw_be | output | 4 | Local write byte enables |
| ack | output | 1 | Write acknowledge pulse |
| peek_idx | input | IDX_W | Bank location to inspect |
| peek_data | output | 32 | Contents of the inspected location |

## Verification
On every cycle, the assertions check the port-level rules of an accepted write: the one-cycle enable, the acknowledge that always follows it, the enable's fixed distance from the falling request, the byte-enable pattern and clean upper byte lanes per mode, and the address window. Only the bench's scenarios can show that the bit pairs end up in the right address and data positions. The same holds for rejected frames (too short, too long, read flag, outside the window), which must stay silent and leave the bank untouched. The bench checks this through the port values and the bank contents read back through the inspection port.

// File: rtl/pairbus_pkg.sv
package pairbus_pkg;

    localparam int ADDR_W     = 17;
    localparam int DATA_W     = 32;
    localparam int BE_W       = DATA_W / 8;
    localparam int HDR_CYC    = 1;
    localparam int ADDR_PAIRS = (ADDR_W - 1) / 2;
    localparam int WORD_PAIRS = DATA_W / 2;
    localparam int BYTE_PAIRS = 8 / 2;
    localparam int DATA_START = HDR_CYC + ADDR_PAIRS;
    localparam int CNT_W      = $clog2(DATA_START + WORD_PAIRS + 1) + 1;

    typedef enum logic {
        MODE_BYTE = 1'b0,
        MODE_WORD = 1'b1
    } width_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } wr_cmd_t;

    function automatic logic [CNT_W-1:0] frame_cycles(width_mode_e m);
        int n;
        n = DATA_START + ((m == MODE_WORD) ? WORD_PAIRS : BYTE_PAIRS);
        return CNT_W'(n);
    endfunction

    function automatic logic [BE_W-1:0] lane_mask(width_mode_e m);
        return (m == MODE_WORD) ? {BE_W{1'b1}} : BE_W'(1);
    endfunction

endpackage

// File: rtl/pairbus_deser.sv
module pairbus_deser
    import pairbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  width_mode_e mode,
    input  logic        req,
    input  logic [1:0]  din,
    output logic        cmd_vld,
    output wr_cmd_t     cmd
);

    logic              req_q;
    logic [CNT_W-1:0]  cnt;
    logic              wflag;
    logic [ADDR_W-1:0] addr_sh;
    logic [DATA_W-1:0] data_sh;
    logic              len_ok;

    assign len_ok = (cnt == frame_cycles(mode));

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            cnt     <= '0;
            wflag   <= 1'b0;
            addr_sh <= '0;
            data_sh <= '0;
            cmd_vld <= 1'b0;
            cmd     <= '0;
        end else begin
            req_q   <= req;
            cmd_vld <= 1'b0;
            if (req) begin
                if (!req_q) begin
                    cnt     <= CNT_W'(1);
                    wflag   <= din[0];
                    addr_sh <= {{(ADDR_W-1){1'b0}}, din[1]};
                    data_sh <= '0;
                end else begin
                    if (cnt != {CNT_W{1'b1}})
                        cnt <= cnt + 1'b1;
                    for (int k = 1; k <= ADDR_PAIRS; k++) begin
                        if (cnt == CNT_W'(k))
                            addr_sh[2*k-1 +: 2] <= din;
                    end
                    for (int j = 0; j < WORD_PAIRS; j++) begin
                        if (cnt == CNT_W'(DATA_START + j))
                            data_sh[2*j +: 2] <= din;
                    end
                end
            end else if (req_q) begin
                cmd_vld   <= wflag && len_ok;
                cmd.addr  <= addr_sh;
                cmd.data  <= (mode == MODE_WORD) ? data_sh
                                                 : {{(DATA_W-8){1'b0}}, data_sh[7:0]};
                cmd.be    <= lane_mask(mode);
            end
        end
    end

endmodule

// File: rtl/pairbus_range_gate.sv
module pairbus_range_gate
    import pairbus_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 17'h1A5C0,
    parameter int                BANK_DEPTH = 8,
    localparam int               IDX_W      = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_vld,
    input  wr_cmd_t          cmd,
    output logic             wr_en,
    output wr_cmd_t          wr_cmd,
    output logic [IDX_W-1:0] wr_idx
);

    localparam logic [ADDR_W:0] LO = {1'b0, BASE_ADDR};
    localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(BANK_DEPTH);

    logic [ADDR_W:0]   addr_x;
    logic              hit;
    logic [ADDR_W-1:0] offs;

    assign addr_x = {1'b0, cmd.addr};
    assign hit    = (addr_x >= LO) && (addr_x < HI);
    assign offs   = cmd.addr - BASE_ADDR;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en  <= 1'b0;
            wr_cmd <= '0;
            wr_idx <= '0;
        end else begin
            wr_en <= cmd_vld && hit;
            if (cmd_vld) begin
                wr_cmd <= cmd;
                wr_idx <= offs[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/pairbus_regbank.sv
module pairbus_regbank
    import pairbus_pkg::*;
#(
    parameter int  BANK_DEPTH = 8,
    localparam int IDX_W      = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   be,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic [DATA_W-1:0] peek_data
);

    logic [DATA_W-1:0] mem [BANK_DEPTH];

    for (genvar loc = 0; loc < BANK_DEPTH; loc++) begin : g_loc
        for (genvar ln = 0; ln < BE_W; ln++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst)
                    mem[loc][8*ln +: 8] <= '0;
                else if (we && be[ln] && (idx == IDX_W'(loc)))
                    mem[loc][8*ln +: 8] <= wdata[8*ln +: 8];
            end
        end
    end

    always_comb begin
        peek_data = '0;
        for (int i = 0; i < BANK_DEPTH; i++) begin
            if (peek_idx == IDX_W'(i))
                peek_data = mem[i];
        end
    end

endmodule

// File: rtl/pairbus_wr_slave.sv
module pairbus_wr_slave
    import pairbus_pkg::*;
#(
    parameter logic [16:0] BASE_ADDR  = 17'h1A5C0,
    parameter int          BANK_DEPTH = 8,
    localparam int         IDX_W      = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wide_mode,
    input  logic             req,
    input  logic [1:0]       din,
    output logic             lw_en,
    output logic [16:0]      lw_addr,
    output logic [31:0]      lw_data,
    output logic [3:0]       lw_be,
    output logic             ack,
    input  logic [IDX_W-1:0] peek_idx,
    output logic [31:0]      peek_data
);

    width_mode_e      mode;
    logic             cmd_vld;
    wr_cmd_t          cmd;
    wr_cmd_t          wr_cmd;
    logic [IDX_W-1:0] wr_idx;

    assign mode = width_mode_e'(wide_mode);

    pairbus_deser u_deser (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .req     (req),
        .din     (din),
        .cmd_vld (cmd_vld),
        .cmd     (cmd)
    );

    pairbus_range_gate #(
        .BASE_ADDR  (BASE_ADDR),
        .BANK_DEPTH (BANK_DEPTH)
    ) u_gate (
        .clk     (clk),
        .rst     (rst),
        .cmd_vld (cmd_vld),
        .cmd     (cmd),
        .wr_en   (lw_en),
        .wr_cmd  (wr_cmd),
        .wr_idx  (wr_idx)
    );

    pairbus_regbank #(
        .BANK_DEPTH (BANK_DEPTH)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .we        (lw_en),
        .idx       (wr_idx),
        .wdata     (wr_cmd.data),
        .be        (wr_cmd.be),
        .peek_idx  (peek_idx),
        .peek_data (peek_data)
    );

    assign lw_addr = wr_cmd.addr;
    assign lw_data = wr_cmd.data;
    assign lw_be   = wr_cmd.be;

    always_ff @(posedge clk) begin
        if (rst) ack <= 1'b0;
        else     ack <= lw_en;
    end

endmodule

// File: rtl/pairbus_wr_slave_chk.sv
module pairbus_wr_slave_chk #(
    parameter logic [16:0] BASE_ADDR  = 17'h1A5C0,
    parameter int          BANK_DEPTH = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        wide_mode,
    input logic        req,
    input logic        lw_en,
    input logic [16:0] lw_addr,
    input logic [31:0] lw_data,
    input logic [3:0]  lw_be,
    input logic        ack
);

    localparam logic [17:0] LO = {1'b0, BASE_ADDR};
    localparam logic [17:0] HI = LO + 18'(BANK_DEPTH);

    p_ack_follows_r7: assert property (@(posedge clk) disable iff (rst)
        lw_en |=> ack);
    p_ack_cause_r7: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(lw_en));
    p_ack_single_r7: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    p_en_single_r6: assert property (@(posedge clk) disable iff (rst)
        lw_en |=> !lw_en);
    p_en_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        lw_en |-> ($past(req, 3) && !$past(req, 2)));
    p_window_r11: assert property (@(posedge clk) disable iff (rst)
        lw_en |-> (({1'b0, lw_addr} >= LO) && ({1'b0, lw_addr} < HI)));
    p_byte_lane_r9: assert property (@(posedge clk) disable iff (rst)
        (lw_en && !wide_mode) |-> (lw_be == 4'b0001 && lw_data[31:8] == 24'd0));
    p_word_lane_r10: assert property (@(posedge clk) disable iff (rst)
        (lw_en && wide_mode) |-> (lw_be == 4'b1111));

endmodule

bind pairbus_wr_slave pairbus_wr_slave_chk #(
    .BASE_ADDR  (BASE_ADDR),
    .BANK_DEPTH (BANK_DEPTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wide_mode (wide_mode),
    .req       (req),
    .lw_en     (lw_en),
    .lw_addr   (lw_addr),
    .lw_data   (lw_data),
    .lw_be     (lw_be),
    .ack       (ack)
);

// File: tb/pairbus_wr_slave_bench.sv
module pairbus_wr_slave_bench;

    localparam logic [16:0] BASE  = 17'h1A5C0;
    localparam int          DEPTH = 8;
    localparam int          IW    = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wide_mode = 1'b1;
    logic        req = 1'b0;
    logic [1:0]  din = 2'b00;
    logic        lw_en;
    logic [16:0] lw_addr;
    logic [31:0] lw_data;
    logic [3:0]  lw_be;
    logic        ack;
    logic [IW-1:0] peek_idx = '0;
    logic [31:0] peek_data;

    pairbus_wr_slave #(.BASE_ADDR(BASE), .BANK_DEPTH(DEPTH)) u_pairbus_wr_slave (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .req(req), .din(din),
        .lw_en(lw_en), .lw_addr(lw_addr), .lw_data(lw_data), .lw_be(lw_be),
        .ack(ack), .peek_idx(peek_idx), .peek_data(peek_data)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [16:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        int          due;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] model [DEPTH];
    int          cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    int          n_wr = 0;
    int          n_ack = 0;
    logic        prev_en = 1'b0;
    string       cur_tag = "R12";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (lw_en) begin
                n_wr++;
                if (sb.size() == 0) begin
                    chk({cur_tag, " unexpected write"}, 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.tag, " R4 addr"}, 32'(lw_addr), 32'(e.addr));
                    chk({e.tag, " R5 data"}, lw_data, e.data);
                    chk({e.tag, " lane mask"}, 32'(lw_be), 32'(e.be));
                    chk({e.tag, " R6 timing"}, cyc, e.due);
                end
            end
            if (ack) n_ack++;
            if (ack || prev_en) chk("R7 ack after write", 32'(ack), 32'(prev_en));
            prev_en = lw_en;
        end
    end

    function automatic logic [1:0] pair_at(int k, logic wf, logic [16:0] a, logic [31:0] d);
        int j;
        if (k == 0) return {a[0], wf};
        if (k <= 8) return {a[2*k], a[2*k-1]};
        j = k - 9;
        if (j < 16) return {d[2*j+1], d[2*j]};
        return 2'b00;
    endfunction

    task automatic send(input string tag, input logic wide, input logic wf,
                        input logic [16:0] a, input logic [31:0] d, input int ncyc,
                        input logic expect_ok);
        int w0;
        int a0;
        @(negedge clk);
        cur_tag   = tag;
        wide_mode = wide;
        w0 = n_wr;
        a0 = n_ack;
        for (int k = 0; k < ncyc; k++) begin
            req = 1'b1;
            din = pair_at(k, wf, a, d);
            @(negedge clk);
        end
        req = 1'b0;
        din = 2'b00;
        if (expect_ok) begin
            exp_t e;
            int ix;
            e.addr = a;
            e.data = wide ? d : {24'd0, d[7:0]};
            e.be   = wide ? 4'hF : 4'h1;
            e.due  = cyc + 2;
            e.tag  = tag;
            sb.push_back(e);
            ix = int'(a - BASE);
            if (wide) model[ix] = d;
            else      model[ix][7:0] = d[7:0];
        end
        repeat (5) @(negedge clk);
        if (!expect_ok) begin
            chk({tag, " no write"}, n_wr - w0, 0);
            chk({tag, " no ack"}, n_ack - a0, 0);
        end
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            peek_idx = IW'(i);
            #1;
            chk($sformatf("%s loc%0d", tag, i), peek_data, model[i]);
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (5) @(negedge clk);
        chk("R12 lw_en in reset", 32'(lw_en), 0);
        chk("R12 ack in reset", 32'(ack), 0);
        rst = 1'b0;
        @(negedge clk);
        check_bank("R12 R13 cleared");

        send("R1 R10 word loc0", 1'b1, 1'b1, BASE, 32'hA5C3_1E7F, 25, 1'b1);
        send("R1 R4 word loc7", 1'b1, 1'b1, BASE + 17'd7, 32'h8001_6DB2, 25, 1'b1);
        send("R1 word loc5", 1'b1, 1'b1, BASE + 17'd5, 32'hFFFF_0000, 25, 1'b1);
        check_bank("R13 R10 after words");
        send("R2 R9 byte loc0", 1'b0, 1'b1, BASE, 32'h0000_003C, 13, 1'b1);
        send("R2 R9 byte loc3", 1'b0, 1'b1, BASE + 17'd3, 32'h0000_00C9, 13, 1'b1);
        check_bank("R9 R13 byte merge");
        send("R10 word overwrite loc0", 1'b1, 1'b1, BASE, 32'h1234_5678, 25, 1'b1);
        send("R8 short word", 1'b1, 1'b1, BASE + 17'd1, 32'hDEAD_BEEF, 24, 1'b0);
        send("R8 long word", 1'b1, 1'b1, BASE + 17'd1, 32'hDEAD_BEEF, 26, 1'b0);
        send("R8 long byte", 1'b0, 1'b1, BASE + 17'd2, 32'h0000_0055, 14, 1'b0);
        send("R8 short byte", 1'b0, 1'b1, BASE + 17'd2, 32'h0000_0055, 12, 1'b0);
        send("R8 byte mode at word length", 1'b0, 1'b1, BASE + 17'd2, 32'h0000_0055, 25, 1'b0);
        send("R3 read flag", 1'b1, 1'b0, BASE + 17'd4, 32'hCAFE_F00D, 25, 1'b0);
        send("R11 above window", 1'b1, 1'b1, BASE + 17'd8, 32'h0BAD_0BAD, 25, 1'b0);
        send("R11 below window", 1'b1, 1'b1, BASE - 17'd1, 32'h0BAD_0BAD, 25, 1'b0);
        check_bank("R3 R8 R11 bank unchanged");
        send("R2 byte loc6 after rejects", 1'b0, 1'b1, BASE + 17'd6, 32'h0000_00A7, 13, 1'b1);
        check_bank("R13 final");
        chk("R6 queue drained", sb.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule